// File: doc/BRIEF.md
# Buck Over-Current Hiccup and Thermal Gate

This block decides, once per switching period, whether the power stage of a step-down regulator may switch. The analog front end hands it three things: a one-clock pulse that marks the end of each switching period, a flag that says whether the high-side current limit tripped in that period, and a digital junction-temperature reading. From these the block produces one gate-enable that the driver logic ANDs into its switch commands.

Under a sustained overload the block lets a short run of limited periods pass, then blanks switching for a fixed number of periods and tries again. This hiccup pattern keeps dissipation bounded during a short circuit. A hot die stops switching completely until it has cooled past a lower release point. Neither fault latches: once the cause goes away, switching resumes with no outside action. Run length, blanking length, thresholds and the width of the temperature code are all parameters. An option adds one register stage on the temperature input.

Top module: `buck_fault_gate`

## Requirements
- R1: After reset, gate_en is 1, hiccup_on is 0 and thermal_off is 0.
- R2: The current-limit flag is sampled only in a clock where cyc_tick is 1. Three consecutive limited periods leave gate_en at 1. The fourth consecutive one sets hiccup_on and clears gate_en from the next clock on.
- R3: A sampled period without current limit resets the consecutive count to zero, so three limited periods, one clean period and three more limited periods do not start blanking.
- R4: A blanking interval lasts exactly seven ticks after the tick that started it. gate_en returns to 1 in the clock after the seventh tick.
- R5: The current-limit flag is ignored while blanking, so it neither extends nor retriggers the interval. After blanking ends, four fresh consecutive limited periods are needed to blank again.
- R6: The current-limit flag has no effect in clocks where cyc_tick is 0.
- R7: temp_code is unsigned and counts whole degrees Celsius. A reading of 140 or more sets thermal_off and clears gate_en in the next clock. A reading of 139 from the cool state does not.
- R8: Once thermal_off is set, it stays set for readings from 126 to 139. It clears, and switching resumes, in the clock after a reading of 125 or below.
- R9: While thermal_off is set, gate_en is 0 and both the consecutive count and the remaining blanking time are frozen. Ticks and current-limit flags are then ignored, and both counts resume where they stopped once the die has cooled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_tick | input | 1 | One-clock pulse at the end of each switching period |
| ocp_flag | input | 1 | High-side current limit was reached in the period that is ending |
| temp_code | input | TEMP_W | Junction temperature in whole degrees Celsius, unsigned |
| gate_en | output | 1 | 1 allows the power stage to switch |
| hiccup_on | output | 1 | A blanking interval is in progress |
| thermal_off | output | 1 | Thermal shutdown is active |

## Verification
The bench targets off-by-one faults in both counters. It checks that the third limited period leaves the gate on and the fourth turns it off, and that the seventh blanking tick, not the sixth or eighth, brings switching back; a counter compared against the wrong limit shows up as a gate edge one tick early or late. It breaks a limited run with one clean period and holds the limit flag high between ticks, which exposes a counter that forgets to clear or that samples without a tick. On the thermal side it steps the reading across 139/140 and 126/125, catching a comparator that uses the wrong bound or has no hysteresis. It also heats the die in the middle of a blanking interval and in the middle of a limited run, then checks that the remaining counts pick up unchanged; a design that let ticks run during shutdown would release early or blank late.

// File: rtl/fltseq_pkg.sv
package fltseq_pkg;

   // thermal supervisor state
   typedef enum logic {
      TH_COOL = 1'b0,
      TH_HOT  = 1'b1
   } therm_state_e;

   // width that can hold the value n
   function automatic int cnt_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/fltseq_thermal.sv
module fltseq_thermal
   import fltseq_pkg::*;
#(
   parameter int TEMP_W     = 8,
   parameter int TRIP_C     = 140,
   parameter int CLEAR_C    = 125,
   parameter bit SYNC_STAGE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TEMP_W-1:0] temp_code,
   output logic              hot
);

   localparam logic [TEMP_W-1:0] TRIP_V  = TEMP_W'(TRIP_C);
   localparam logic [TEMP_W-1:0] CLEAR_V = TEMP_W'(CLEAR_C);

   logic [TEMP_W-1:0] temp_v;
   therm_state_e      st_q;
   therm_state_e      st_d;

   // optional retiming of the temperature reading
   generate
      if (SYNC_STAGE) begin : g_sync
         logic [TEMP_W-1:0] temp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) temp_q <= '0;
            else        temp_q <= temp_code;
         end
         assign temp_v = temp_q;
      end else begin : g_direct
         assign temp_v = temp_code;
      end
   endgenerate

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         TH_COOL: if (temp_v >= TRIP_V)  st_d = TH_HOT;
         TH_HOT:  if (temp_v <= CLEAR_V) st_d = TH_COOL;
         default: st_d = TH_COOL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= TH_COOL;
      else        st_q <= st_d;
   end

   assign hot = (st_q == TH_HOT);

endmodule

// File: rtl/fltseq_streak.sv
module fltseq_streak
   import fltseq_pkg::*;
#(
   parameter int LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic ocp,
   output logic fire
);

   localparam int            CW   = cnt_width(LEN - 1);
   localparam logic [CW-1:0] LAST = CW'(LEN - 1);

   logic [CW-1:0] run_q;

   assign fire = step && ocp && (run_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (step) begin
         if (!ocp || run_q == LAST) run_q <= '0;
         else                       run_q <= run_q + 1'b1;
      end
   end

endmodule

// File: rtl/fltseq_blank.sv
module fltseq_blank
   import fltseq_pkg::*;
#(
   parameter int LEN = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic step,
   output logic active
);

   localparam int            CW     = cnt_width(LEN);
   localparam logic [CW-1:0] LOAD_V = CW'(LEN);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     left_q <= '0;
      else if (load)                  left_q <= LOAD_V;
      else if (step && left_q != '0)  left_q <= left_q - 1'b1;
   end

   assign active = (left_q != '0);

endmodule

// File: rtl/buck_fault_gate.sv
module buck_fault_gate #(
   parameter int TEMP_W     = 8,
   parameter int STREAK_LEN = 4,
   parameter int BLANK_LEN  = 7,
   parameter int TRIP_C     = 140,
   parameter int CLEAR_C    = 125,
   parameter bit SYNC_TEMP  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_tick,
   input  logic              ocp_flag,
   input  logic [TEMP_W-1:0] temp_code,
   output logic              gate_en,
   output logic              hiccup_on,
   output logic              thermal_off
);

   // elaboration-time parameter checks
   generate
      if (STREAK_LEN < 1) begin : g_bad_streak
         $error("STREAK_LEN must be at least 1");
      end
      if (BLANK_LEN < 1) begin : g_bad_blank
         $error("BLANK_LEN must be at least 1");
      end
      if (CLEAR_C >= TRIP_C) begin : g_bad_hyst
         $error("CLEAR_C must be below TRIP_C");
      end
      if (TRIP_C >= (1 << TEMP_W)) begin : g_bad_width
         $error("TRIP_C does not fit in TEMP_W bits");
      end
   endgenerate

   logic hot;
   logic blanking;
   logic fire;
   logic streak_step;
   logic blank_step;

   fltseq_thermal #(
      .TEMP_W    (TEMP_W),
      .TRIP_C    (TRIP_C),
      .CLEAR_C   (CLEAR_C),
      .SYNC_STAGE(SYNC_TEMP)
   ) u_therm (
      .clk      (clk),
      .rst_n    (rst_n),
      .temp_code(temp_code),
      .hot      (hot)
   );

   // thermal shutdown freezes both counters
   assign streak_step = cyc_tick && !hot && !blanking;
   assign blank_step  = cyc_tick && !hot;

   fltseq_streak #(
      .LEN(STREAK_LEN)
   ) u_streak (
      .clk  (clk),
      .rst_n(rst_n),
      .step (streak_step),
      .ocp  (ocp_flag),
      .fire (fire)
   );

   fltseq_blank #(
      .LEN(BLANK_LEN)
   ) u_blank (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (fire),
      .step  (blank_step),
      .active(blanking)
   );

   assign gate_en     = !hot && !blanking;
   assign hiccup_on   = blanking;
   assign thermal_off = hot;

endmodule

// File: rtl/buck_fault_gate_chk.sv
module buck_fault_gate_chk #(
   parameter int TEMP_W     = 8,
   parameter int STREAK_LEN = 4,
   parameter int BLANK_LEN  = 7,
   parameter int TRIP_C     = 140,
   parameter int CLEAR_C    = 125,
   parameter bit SYNC_TEMP  = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cyc_tick,
   input logic              ocp_flag,
   input logic [TEMP_W-1:0] temp_code,
   input logic              gate_en,
   input logic              hiccup_on,
   input logic              thermal_off
);

   localparam int SCW = $clog2(STREAK_LEN + 1) + 1;
   localparam int BCW = $clog2(BLANK_LEN + 1) + 1;

   logic [SCW-1:0] seen_run;
   logic [BCW-1:0] seen_blank;

   // independent tally of consecutive limited periods
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         seen_run <= '0;
      else if (hiccup_on)                 seen_run <= '0;
      else if (cyc_tick && !thermal_off)  seen_run <= ocp_flag ? seen_run + 1'b1 : '0;
   end

   // independent tally of live ticks inside one blanking interval
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         seen_blank <= '0;
      else if (!hiccup_on)                seen_blank <= '0;
      else if (cyc_tick && !thermal_off)  seen_blank <= seen_blank + 1'b1;
   end

   // R2 R3: blanking starts only after the full run of limited periods
   p_run_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hiccup_on) |-> seen_run == SCW'(STREAK_LEN));

   // R4: blanking spans exactly BLANK_LEN live ticks
   p_blank_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hiccup_on) |-> seen_blank == BCW'(BLANK_LEN));

   // R4: no switching while blanking
   p_blank_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hiccup_on |-> !gate_en);

   // R6: nothing moves the hiccup state without a tick
   p_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_tick |=> $stable(hiccup_on));

   // R9: shutdown blocks switching and freezes blanking
   p_hot_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      thermal_off |-> !gate_en);

   p_hot_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      thermal_off |=> $stable(hiccup_on));

   generate
      if (!SYNC_TEMP) begin : g_direct_temp
         // R7: trip at the threshold
         p_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (temp_code >= TEMP_W'(TRIP_C)) |=> thermal_off);

         // R8: hold inside the hysteresis band, release at or below the low point
         p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (thermal_off && temp_code > TEMP_W'(CLEAR_C)) |=> thermal_off);

         p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (temp_code <= TEMP_W'(CLEAR_C)) |=> !thermal_off);
      end
   endgenerate

endmodule

bind buck_fault_gate buck_fault_gate_chk #(
   .TEMP_W    (TEMP_W),
   .STREAK_LEN(STREAK_LEN),
   .BLANK_LEN (BLANK_LEN),
   .TRIP_C    (TRIP_C),
   .CLEAR_C   (CLEAR_C),
   .SYNC_TEMP (SYNC_TEMP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cyc_tick   (cyc_tick),
   .ocp_flag   (ocp_flag),
   .temp_code  (temp_code),
   .gate_en    (gate_en),
   .hiccup_on  (hiccup_on),
   .thermal_off(thermal_off)
);

// File: tb/buck_fault_gate_test.sv
module buck_fault_gate_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_tick = 1'b0;
   logic       ocp_flag = 1'b0;
   logic [7:0] temp_code = 8'd40;
   logic       gate_en;
   logic       hiccup_on;
   logic       thermal_off;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   buck_fault_gate uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cyc_tick   (cyc_tick),
      .ocp_flag   (ocp_flag),
      .temp_code  (temp_code),
      .gate_en    (gate_en),
      .hiccup_on  (hiccup_on),
      .thermal_off(thermal_off)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   // one switching period: tick for one clock, then sample at the next negedge
   task automatic do_tick(input logic oc);
      cyc_tick = 1'b1;
      ocp_flag = oc;
      @(negedge clk);
      cyc_tick = 1'b0;
      ocp_flag = 1'b0;
      @(negedge clk);
   endtask

   task automatic set_temp(input int t);
      temp_code = 8'(t);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1", "gate_en after reset", gate_en, 1'b1);
      chk("R1", "hiccup_on after reset", hiccup_on, 1'b0);
      chk("R1", "thermal_off after reset", thermal_off, 1'b0);
   endtask

   task automatic t_run_and_blank();
      for (int i = 0; i < 3; i++) begin
         do_tick(1'b1);
         chk("R2", "gate_en during first three limited periods", gate_en, 1'b1);
      end
      do_tick(1'b1);
      chk("R2", "gate_en after fourth limited period", gate_en, 1'b0);
      chk("R2", "hiccup_on after fourth limited period", hiccup_on, 1'b1);
      for (int i = 0; i < 6; i++) begin
         do_tick(1'b1);
         chk("R4", "gate_en during blanking ticks 1..6", gate_en, 1'b0);
      end
      do_tick(1'b1);
      chk("R4", "gate_en after seventh blanking tick", gate_en, 1'b1);
      chk("R5", "limit flag during blanking did not extend it", hiccup_on, 1'b0);
      for (int i = 0; i < 3; i++) begin
         do_tick(1'b1);
         chk("R5", "count restarted from zero after blanking", gate_en, 1'b1);
      end
      do_tick(1'b1);
      chk("R5", "fourth fresh limited period blanks again", gate_en, 1'b0);
      for (int i = 0; i < 7; i++) do_tick(1'b0);
      chk("R4", "gate_en after clean blanking interval", gate_en, 1'b1);
   endtask

   task automatic t_break_run();
      for (int i = 0; i < 3; i++) do_tick(1'b1);
      do_tick(1'b0);
      for (int i = 0; i < 3; i++) do_tick(1'b1);
      chk("R3", "clean period resets the run", gate_en, 1'b1);
      chk("R3", "no blanking after broken run", hiccup_on, 1'b0);
      do_tick(1'b0);
   endtask

   task automatic t_no_tick();
      ocp_flag = 1'b1;
      for (int i = 0; i < 10; i++) @(negedge clk);
      ocp_flag = 1'b0;
      chk("R6", "limit flag without tick leaves gate on", gate_en, 1'b1);
      for (int i = 0; i < 3; i++) do_tick(1'b1);
      chk("R6", "untimed flag was not counted", gate_en, 1'b1);
      do_tick(1'b0);
   endtask

   task automatic t_thermal();
      set_temp(139);
      chk("R7", "139 C does not trip", thermal_off, 1'b0);
      set_temp(140);
      chk("R7", "140 C trips shutdown", thermal_off, 1'b1);
      chk("R7", "gate_en off at 140 C", gate_en, 1'b0);
      set_temp(130);
      chk("R8", "still off at 130 C", thermal_off, 1'b1);
      set_temp(126);
      chk("R8", "still off at 126 C", gate_en, 1'b0);
      set_temp(125);
      chk("R8", "released at 125 C", thermal_off, 1'b0);
      chk("R8", "gate_en back on at 125 C", gate_en, 1'b1);
      set_temp(200);
      chk("R7", "200 C trips shutdown", gate_en, 1'b0);
      set_temp(60);
      chk("R8", "released at 60 C", gate_en, 1'b1);
   endtask

   task automatic t_freeze();
      for (int i = 0; i < 4; i++) do_tick(1'b1);
      do_tick(1'b0);
      do_tick(1'b0);
      set_temp(150);
      for (int i = 0; i < 20; i++) do_tick(1'b1);
      chk("R9", "blanking frozen while hot", hiccup_on, 1'b1);
      chk("R9", "gate_en off while hot", gate_en, 1'b0);
      set_temp(100);
      chk("R9", "blanking resumes after cooling", gate_en, 1'b0);
      for (int i = 0; i < 4; i++) do_tick(1'b0);
      chk("R9", "four of five remaining ticks still blank", gate_en, 1'b0);
      do_tick(1'b0);
      chk("R9", "frozen blanking ends on its fifth remaining tick", gate_en, 1'b1);
      for (int i = 0; i < 3; i++) do_tick(1'b1);
      set_temp(145);
      for (int i = 0; i < 5; i++) do_tick(1'b1);
      set_temp(90);
      chk("R9", "run count held while hot", hiccup_on, 1'b0);
      do_tick(1'b1);
      chk("R9", "held run of three plus one blanks", gate_en, 1'b0);
      for (int i = 0; i < 7; i++) do_tick(1'b0);
      chk("R9", "gate_en after blanking", gate_en, 1'b1);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_run_and_blank();
      t_break_run();
      t_no_tick();
      t_thermal();
      t_freeze();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule